// File: doc/BRIEF.md
# Page Write-Protect Guard

This block sits between a request source and a 32 KB RAM and stops writes into any 1 KB page that software has locked. A configuration register holds one bit per page. Software can only add protection to it. A page bit goes back to zero only through a system reset. Each incoming memory request is examined. Reads always go through. A write to an unlocked page goes through. A write to a locked page is removed from the outgoing port, and the block raises a one-cycle fault pulse in its place.

Every forwarded request and every fault comes out exactly one clock after the request is presented. The page index is the top field of the byte address, above the 1 KB offset. Changes to the lock register take effect on the clock edge that follows the configuration write.

Top module: `page_wp_guard`

## Requirements
- R1: After reset the lock register reads 0x00000000, and memValid and wrFault are 0.
- R2: A configuration write ORs cfgWrData into the lock register. A 0 bit in cfgWrData leaves the matching lock bit unchanged, so a set bit can be cleared only by reset.
- R3: cfgRdData always shows the current lock register. A configuration write becomes visible there one cycle after cfgWrEn is sampled high.
- R4: The page of a request is reqAddr[14:10]. Lock bit x (1 = locked, 0 = writable) governs page x, for x from 0 to 31.
- R5: A write (reqWrite=1) to an unlocked page appears on the memory port one cycle later. That cycle has memValid=1, memWrite=1, and memAddr and memWdata equal to the request.
- R6: A write to a locked page gives memValid=0 in the following cycle. wrFault is 1 in that cycle only.
- R7: A read (reqWrite=0) is forwarded one cycle later with memValid=1 and memWrite=0, whatever the lock state of its page.
- R8: A request presented in the same cycle as a configuration write is judged against the lock register as it was before that write.
- R9: A cycle with reqValid=0 gives memValid=0 and wrFault=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| cfgWrEn | input | 1 | Configuration write strobe for the lock register |
| cfgWrData | input | 32 | Bits to set in the lock register |
| cfgRdData | output | 32 | Current lock register value |
| reqValid | input | 1 | Incoming memory request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Byte address of the request |
| reqWdata | input | 32 | Write data |
| memValid | output | 1 | Request forwarded to the RAM |
| memWrite | output | 1 | Forwarded request is a write |
| memAddr | output | 15 | Forwarded address |
| memWdata | output | 32 | Forwarded write data |
| wrFault | output | 1 | One-cycle pulse for a dropped write |

## Verification
The bench builds the block with its default parameters: a 15-bit address, a 10-bit page offset, 32 pages and 32-bit data. With these values every lock bit can be reached by both random and directed traffic. The directed cases hit the first and last byte of a page, including the byte on either side of a page edge (0x3FF and 0x400), and the top page 31. A random phase then mixes reads, writes and sparse configuration writes, some of which try to write 0 over bits that are already locked. A final reset shows that the lock register clears.

// File: rtl/page_wp_pkg.sv
package page_wp_pkg;

  // Strobes passed from the control decision to the datapath
  typedef struct packed {
    logic fwd;      // forward the current request
    logic fault;    // raise the write fault pulse
    logic setLock;  // OR configuration data into the lock register
  } guardStrb_t;

endpackage

// File: rtl/page_wp_ctrl.sv
module page_wp_ctrl
  import page_wp_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_OFF_W = 10,
  localparam int PAGE_IDX_W = ADDR_W - PAGE_OFF_W,
  localparam int NUM_PAGES  = 1 << PAGE_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_PAGES-1:0] lockMask,
  output guardStrb_t           strb
);

  logic [PAGE_IDX_W-1:0] pageIdx;
  logic                  pageLocked;

  assign pageIdx    = reqAddr[ADDR_W-1:PAGE_OFF_W];
  assign pageLocked = lockMask[pageIdx];

  always_comb begin
    strb         = '0;
    strb.setLock = cfgWrEn;
    if (reqValid) begin
      if (reqWrite && pageLocked) strb.fault = 1'b1;
      else                        strb.fwd   = 1'b1;
    end
  end

  AST_FWD_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.fwd && strb.fault)); // R6
  AST_READ_NEVER_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |-> strb.fwd); // R7

endmodule

// File: rtl/page_wp_dp.sv
module page_wp_dp
  import page_wp_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_OFF_W = 10,
  parameter int DATA_W     = 32,
  localparam int PAGE_IDX_W = ADDR_W - PAGE_OFF_W,
  localparam int NUM_PAGES  = 1 << PAGE_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  guardStrb_t           strb,
  input  logic [NUM_PAGES-1:0] cfgWrData,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic [NUM_PAGES-1:0] lockMask,
  output logic                 memValid,
  output logic                 memWrite,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic                 wrFault
);

  // Sticky lock bits: set-only, cleared by reset alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lockMask <= '0;
    else if (strb.setLock) lockMask <= lockMask | cfgWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memWrite <= 1'b0;
      wrFault  <= 1'b0;
    end else begin
      memValid <= strb.fwd;
      memWrite <= strb.fwd & reqWrite;
      wrFault  <= strb.fault;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWdata <= '0;
    end else if (strb.fwd) begin
      memAddr  <= reqAddr;
      memWdata <= reqWdata;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockMask) & ~lockMask) == '0); // R2
  AST_FAULT_NO_FWD: assert property (@(posedge clk) disable iff (!rstN)
    wrFault |-> !memValid); // R6

endmodule

// File: rtl/page_wp_guard.sv
module page_wp_guard
  import page_wp_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_OFF_W = 10,
  parameter int DATA_W     = 32,
  localparam int PAGE_IDX_W = ADDR_W - PAGE_OFF_W,
  localparam int NUM_PAGES  = 1 << PAGE_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [NUM_PAGES-1:0] cfgWrData,
  output logic [NUM_PAGES-1:0] cfgRdData,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 memValid,
  output logic                 memWrite,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic                 wrFault
);

  guardStrb_t           strb;
  logic [NUM_PAGES-1:0] lockMask;

  page_wp_ctrl #(.ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .lockMask (lockMask),
    .strb     (strb)
  );

  page_wp_dp #(.ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W), .DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWrData (cfgWrData),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .lockMask  (lockMask),
    .memValid  (memValid),
    .memWrite  (memWrite),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .wrFault   (wrFault)
  );

  assign cfgRdData = lockMask;

  AST_LOCKED_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && cfgRdData[reqAddr[ADDR_W-1:PAGE_OFF_W]]) |=> (wrFault && !memValid)); // R6
  AST_OPEN_WRITE_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !cfgRdData[reqAddr[ADDR_W-1:PAGE_OFF_W]]) |=> (memValid && memWrite && memAddr == $past(reqAddr))); // R5
  AST_READ_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> (memValid && !memWrite && !wrFault)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!memValid && !wrFault)); // R9
  AST_CFG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> ((cfgRdData & $past(cfgWrData)) == $past(cfgWrData))); // R3

endmodule

// File: tb/test_page_wp_guard.sv
module test_page_wp_guard;

  localparam int ADDR_W = 15;
  localparam int DATA_W = 32;
  localparam int NP     = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [NP-1:0]     cfgWrData = '0;
  logic [NP-1:0]     cfgRdData;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              memValid, memWrite, wrFault;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;

  int errCnt = 0;
  int chkCnt = 0;

  // Bench model of the lock register
  logic [NP-1:0] mdlLock = '0;

  always #5 clk = ~clk;

  page_wp_guard i_page_wp_guard (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata), .wrFault(wrFault)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic locked(logic [NP-1:0] m, logic [ADDR_W-1:0] a);
    return m[a[14:10]]; // R4 page field
  endfunction

  // Present one cycle of stimulus at negedge, then check results at next negedge
  task automatic step(logic v, logic w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                      logic ce, logic [NP-1:0] cd);
    logic blocked;
    logic [NP-1:0] oldLock;
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    cfgWrEn = ce; cfgWrData = cd;
    oldLock = mdlLock;
    blocked = v && w && locked(oldLock, a); // R8: judged on old mask
    if (ce) mdlLock = mdlLock | cd;        // R2
    @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b0;
    check("R3 cfgRdData", 64'(cfgRdData), 64'(mdlLock));
    if (!v) begin
      check("R9 memValid idle", 64'(memValid), 0);
      check("R9 wrFault idle", 64'(wrFault), 0);
    end else if (blocked) begin
      check("R6 memValid dropped", 64'(memValid), 0);
      check("R6 wrFault", 64'(wrFault), 1);
    end else begin
      check(w ? "R5 memValid" : "R7 memValid", 64'(memValid), 1);
      check(w ? "R5 memWrite" : "R7 memWrite", 64'(memWrite), 64'(w));
      check(w ? "R5 wrFault" : "R7 wrFault", 64'(wrFault), 0);
      check(w ? "R5 memAddr" : "R7 memAddr", 64'(memAddr), 64'(a));
      if (w) check("R5 memWdata", 64'(memWdata), 64'(d));
    end
  endtask

  task automatic pulse_reset();
    rstN = 1'b0;
    mdlLock = '0;
    repeat (2) @(negedge clk);
    check("R1 lock after reset", 64'(cfgRdData), 0);
    check("R1 memValid after reset", 64'(memValid), 0);
    check("R1 wrFault after reset", 64'(wrFault), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    pulse_reset();

    // Directed: everything writable after reset (R1)
    step(1, 1, 15'h0000, 32'hA5A5_0001, 0, '0);
    step(0, 0, 15'h0000, 32'h0, 0, '0);                 // R9 idle
    // Lock pages 0 and 31, request in same cycle uses old mask (R8)
    step(1, 1, 15'h0010, 32'h1111_2222, 1, 32'h8000_0001);
    step(1, 1, 15'h03FF, 32'hDEAD_0000, 0, '0);         // R6 page 0 last byte
    step(1, 1, 15'h0400, 32'hBEEF_0001, 0, '0);         // R4 page 1 first byte open
    step(1, 1, 15'h7C00, 32'hBEEF_0031, 0, '0);         // R6 page 31
    step(1, 1, 15'h7BFF, 32'hBEEF_0030, 0, '0);         // R4 page 30 open
    step(1, 0, 15'h0004, 32'h0, 0, '0);                 // R7 read of locked page
    step(1, 0, 15'h7FFC, 32'h0, 0, '0);                 // R7
    // Writing zeros must not clear (R2)
    step(0, 0, 15'h0, 32'h0, 1, 32'h0000_0000);
    step(1, 1, 15'h0000, 32'h1234_5678, 0, '0);         // R6 still locked
    // Lock page 5 while writing to it in the same cycle (R8), then blocked
    step(1, 1, 15'h1400, 32'h5555_0000, 1, 32'h0000_0020);
    step(1, 1, 15'h1400, 32'h5555_0001, 0, '0);         // R6

    // Constrained random phase
    for (int i = 0; i < 600; i++) begin
      logic ce;
      logic [NP-1:0] cd;
      ce = ($urandom % 30) == 0;
      cd = ($urandom % 4 == 0) ? '0 : (32'h1 << ($urandom % 32));
      step(($urandom % 4) != 0, $urandom % 2, 15'($urandom), $urandom, ce, cd);
    end

    // Reset clears sticky bits (R1)
    pulse_reset();
    step(1, 1, 15'h0000, 32'hCAFE_F00D, 0, '0);         // R5 writable again

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule